// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Cell

This block models a single programmable logic cell of the kind tiled across a reconfigurable fabric. A 16-entry truth table, indexed by four data inputs, produces any Boolean function of those inputs. A register follows the table, and a configuration bit decides whether the cell's main output shows the table result directly or the registered value. The register output is also exported as a chain output so that neighbouring cells can be strung into a shift path.

Beyond the table-plus-register core, the cell can feed its own register back into the table, load its register from the neighbour's chain output, let the table and register work on separate data at the same time, and pass or generate a carry for chained arithmetic. Truth-table contents and mode bits are written in parallel through a write strobe. Routing between cells is outside the block.

Top module: `cfg_logic_cell`

## Requirements
- R1: With feedback and arithmetic off and the select bit at 0, `le_out` equals truth-table bit number `din` (bit i of `cfg_lut` answers input value i), for every input value and any table contents.
- R2: Table contents 16'h9999 make `le_out` the equivalence of `din[1]` and `din[0]` (1 for 00 and 11, 0 for 01 and 10).
- R3: Mode bit 0 (select) set to 1 makes `le_out` follow the register output instead of the table.
- R4: With source field mode[4:3] at 00 (or 11) and `ce` high, the register captures the table result at a rising edge; `q_out` shows it after that edge.
- R5: Mode bit 1 (feedback) replaces table index bit 3 with the register output, so `din[3]` has no effect and the cell can toggle on its own state.
- R6: Source field 01 makes the register load `chain_in`; `chain_out` always equals `q_out`.
- R7: Source field 10 makes the register load `din[3]` while the table keeps driving `le_out` from all four inputs.
- R8: With mode bit 2 (arithmetic) at 0, `carry_out` equals `carry_in`.
- R9: With mode bit 2 at 1, table index bit 2 is replaced by `carry_in`, and `carry_out` is the majority of `din[0]`, `din[1]` and `carry_in`.
- R10: Table and mode are taken from `cfg_lut`/`cfg_mode` only at rising edges where `cfg_we` is high; at other times those inputs have no effect.
- R11: `rst` high at a rising edge clears the register, even when `ce` is low.
- R12: With `rst` low and `ce` low the register holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high register clear |
| ce | input | 1 | Register clock enable |
| din | input | 4 | Data inputs indexing the truth table |
| chain_in | input | 1 | Register output of the neighbouring cell |
| carry_in | input | 1 | Carry from the neighbouring cell |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_lut | input | 16 | Truth-table contents |
| cfg_mode | input | 5 | Mode: [0] select, [1] feedback, [2] arithmetic, [4:3] register source |
| le_out | output | 1 | Selected cell output (table or register) |
| q_out | output | 1 | Register output |
| chain_out | output | 1 | Register output toward the next cell |
| carry_out | output | 1 | Carry toward the next cell |

## Verification
Table output and carry are combinational from `din`, `carry_in` and the stored configuration, so their checks sample a nanosecond after the inputs change, well inside the same clock period. Register results (`q_out`, `chain_out`, and `le_out` in registered select) are due at the first rising edge after the stimulus, and are read two nanoseconds after that edge, where inputs for the next step are also driven. A configuration write takes effect at the edge that sees `cfg_we` high, so each scenario writes its configuration one full step before its first check.

// File: rtl/cle_pkg.sv
package cle_pkg;

  typedef enum logic [1:0] {
    SRC_LUT   = 2'b00,
    SRC_CHAIN = 2'b01,
    SRC_PACK  = 2'b10,
    SRC_LUT2  = 2'b11
  } reg_src_e;

  // Packed MSB first: src [4:3], arith [2], fback [1], sel_q [0]
  typedef struct packed {
    reg_src_e src;
    logic     arith;
    logic     fback;
    logic     sel_q;
  } cle_mode_t;

  localparam int MODE_W = $bits(cle_mode_t);

endpackage

// File: rtl/cle_cfg.sv
module cle_cfg
  import cle_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             cfg_we,
  input  logic [DEPTH-1:0] lut_in,
  input  logic [MODE_W-1:0] mode_in,
  output logic [DEPTH-1:0] lut_q,
  output cle_mode_t        mode_q
);

  // Configuration cells: written only on the strobe, never cleared by reset
  always_ff @(posedge clk) begin
    if (cfg_we) begin
      lut_q  <= lut_in;
      mode_q <= cle_mode_t'(mode_in);
    end
  end

endmodule

// File: rtl/cle_lut.sv
module cle_lut #(
  parameter int K = 4,
  localparam int DEPTH = 1 << K
) (
  input  logic [DEPTH-1:0] truth,
  input  logic [K-1:0]     sel,
  output logic             y
);

  assign y = truth[sel];

endmodule

// File: rtl/cle_ff.sv
module cle_ff
  import cle_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     ce,
  input  reg_src_e src,
  input  logic     lut_d,
  input  logic     chain_d,
  input  logic     pack_d,
  output logic     q
);

  logic d;

  always_comb begin
    unique case (src)
      SRC_CHAIN: d = chain_d;
      SRC_PACK:  d = pack_d;
      default:   d = lut_d;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (ce)  q <= d;
  end

endmodule

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell
  import cle_pkg::*;
#(
  parameter int K = 4,
  localparam int DEPTH   = 1 << K,
  localparam int FB_BIT  = K - 1,
  localparam int CIN_BIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic [K-1:0]      din,
  input  logic              chain_in,
  input  logic              carry_in,
  input  logic              cfg_we,
  input  logic [DEPTH-1:0]  cfg_lut,
  input  logic [MODE_W-1:0] cfg_mode,
  output logic              le_out,
  output logic              q_out,
  output logic              chain_out,
  output logic              carry_out
);

  logic [DEPTH-1:0] lut_q;
  cle_mode_t        mode_q;
  logic [K-1:0]     idx;
  logic             lut_y;
  logic             q;

  cle_cfg #(.DEPTH(DEPTH)) u_cfg (
    .clk     (clk),
    .cfg_we  (cfg_we),
    .lut_in  (cfg_lut),
    .mode_in (cfg_mode),
    .lut_q   (lut_q),
    .mode_q  (mode_q)
  );

  // Index steering: feedback takes the top input, arithmetic takes input 2
  always_comb begin
    idx = din;
    if (mode_q.fback) idx[FB_BIT]  = q;
    if (mode_q.arith) idx[CIN_BIT] = carry_in;
  end

  cle_lut #(.K(K)) u_lut (
    .truth (lut_q),
    .sel   (idx),
    .y     (lut_y)
  );

  cle_ff u_ff (
    .clk     (clk),
    .rst     (rst),
    .ce      (ce),
    .src     (mode_q.src),
    .lut_d   (lut_y),
    .chain_d (chain_in),
    .pack_d  (din[FB_BIT]),
    .q       (q)
  );

  logic maj;
  assign maj = (din[0] & din[1]) | (din[0] & carry_in) | (din[1] & carry_in);

  assign carry_out = mode_q.arith ? maj : carry_in;
  assign le_out    = mode_q.sel_q ? q : lut_y;
  assign q_out     = q;
  assign chain_out = q;

endmodule

// File: rtl/cle_checker.sv
module cle_checker #(
  parameter int K = 4,
  parameter int MW = 5,
  localparam int DEPTH = 1 << K
) (
  input logic             clk,
  input logic             rst,
  input logic             ce,
  input logic [K-1:0]     din,
  input logic             chain_in,
  input logic             carry_in,
  input logic             cfg_we,
  input logic [MW-1:0]    mode,
  input logic [DEPTH-1:0] lut,
  input logic             le_out,
  input logic             q_out,
  input logic             chain_out,
  input logic             carry_out
);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !q_out); // R11

  AST_HOLD_NO_CE: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(q_out)); // R12

  AST_CHAIN_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (ce && mode[4:3] == 2'b01) |=> q_out == $past(chain_in)); // R6

  AST_CHAIN_OUT: assert property (@(posedge clk) disable iff (rst)
    chain_out == q_out); // R6

  AST_PACK_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (ce && mode[4:3] == 2'b10) |=> q_out == $past(din[K-1])); // R7

  AST_SEL_REG: assert property (@(posedge clk) disable iff (rst)
    mode[0] |-> le_out == q_out); // R3

  AST_FEEDBACK_IDX: assert property (@(posedge clk) disable iff (rst)
    (mode[1] && !mode[2] && !mode[0]) |-> le_out == lut[{q_out, din[K-2:0]}]); // R5

  AST_CARRY_PASS: assert property (@(posedge clk) disable iff (rst)
    !mode[2] |-> carry_out == carry_in); // R8

  AST_CARRY_MAJ: assert property (@(posedge clk) disable iff (rst)
    mode[2] |-> carry_out == ((din[0] + din[1] + carry_in) >= 2)); // R9

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> ($stable(lut) && $stable(mode))); // R10

endmodule

bind cfg_logic_cell cle_checker #(.K(K), .MW(cle_pkg::MODE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ce        (ce),
  .din       (din),
  .chain_in  (chain_in),
  .carry_in  (carry_in),
  .cfg_we    (cfg_we),
  .mode      (mode_q),
  .lut       (lut_q),
  .le_out    (le_out),
  .q_out     (q_out),
  .chain_out (chain_out),
  .carry_out (carry_out)
);

// File: tb/tb_cfg_logic_cell.sv
`timescale 1ns/1ps
module tb_cfg_logic_cell;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce = 1'b1;
  logic [3:0]  din = '0;
  logic        chain_in = 1'b0;
  logic        carry_in = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_lut = '0;
  logic [4:0]  cfg_mode = '0;
  logic        le_out, q_out, chain_out, carry_out;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cfg_logic_cell dut (
    .clk(clk), .rst(rst), .ce(ce), .din(din), .chain_in(chain_in),
    .carry_in(carry_in), .cfg_we(cfg_we), .cfg_lut(cfg_lut),
    .cfg_mode(cfg_mode), .le_out(le_out), .q_out(q_out),
    .chain_out(chain_out), .carry_out(carry_out)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic load_cfg(input logic [15:0] lut, input logic [4:0] mode);
    cfg_lut = lut; cfg_mode = mode; cfg_we = 1'b1;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic clear_reg();
    rst = 1'b1; step(); rst = 1'b0;
  endtask

  task automatic t_reset();
    clear_reg();
    chk("R11 reset state", q_out, 1'b0);
    load_cfg(16'hFFFF, 5'b00000);
    ce = 1'b1; step();
    chk("R4 capture ones", q_out, 1'b1);
    rst = 1'b1; ce = 1'b0; step(); rst = 1'b0; ce = 1'b1;
    chk("R11 reset over ce", q_out, 1'b0);
  endtask

  task automatic t_any_function();
    logic [15:0] pats [2] = '{16'hA5C3, 16'h6996};
    foreach (pats[p]) begin
      load_cfg(pats[p], 5'b00000);
      for (int i = 0; i < 16; i++) begin
        din = 4'(i); #1;
        chk("R1 table lookup", le_out, pats[p][i]);
      end
    end
  endtask

  task automatic t_xnor();
    load_cfg(16'h9999, 5'b00000);
    for (int i = 0; i < 4; i++) begin
      din = {2'b00, 2'(i)}; #1;
      chk("R2 equivalence", le_out, ~(din[1] ^ din[0]));
    end
  endtask

  task automatic t_reg_path();
    load_cfg(16'hAAAA, 5'b00001);
    clear_reg();
    din = 4'b0001; #1;
    chk("R3 select shows old reg", le_out, 1'b0);
    step();
    chk("R4 reg captured", q_out, 1'b1);
    chk("R3 select shows reg", le_out, 1'b1);
  endtask

  task automatic t_ce_hold();
    ce = 1'b0; din = 4'b0000; step();
    chk("R12 hold", q_out, 1'b1);
    step();
    chk("R12 hold again", q_out, 1'b1);
    ce = 1'b1; step();
    chk("R12 resume", q_out, 1'b0);
  endtask

  task automatic t_feedback();
    load_cfg(16'h00FF, 5'b00010);
    clear_reg();
    din = 4'b1000; #1;
    chk("R5 din3 ignored", le_out, 1'b1);
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R5 toggle", q_out, (i % 2 == 0) ? 1'b1 : 1'b0);
    end
  endtask

  task automatic t_chain();
    logic [3:0] seq = 4'b1101;
    load_cfg(16'h0000, 5'b01000);
    clear_reg();
    for (int i = 0; i < 4; i++) begin
      chain_in = seq[i]; step();
      chk("R6 chain q", q_out, seq[i]);
      chk("R6 chain out", chain_out, seq[i]);
    end
    chain_in = 1'b0;
  endtask

  task automatic t_pack();
    load_cfg(16'hAAAA, 5'b10000);
    clear_reg();
    din = 4'b1000; #1;
    chk("R7 table independent", le_out, 1'b0);
    step();
    chk("R7 reg took din3", q_out, 1'b1);
    din = 4'b0001; #1;
    chk("R7 table still live", le_out, 1'b1);
    step();
    chk("R7 reg took din3 low", q_out, 1'b0);
  endtask

  task automatic t_carry();
    load_cfg(16'h0000, 5'b00000);
    din = 4'b0011;
    carry_in = 1'b1; #1; chk("R8 pass one", carry_out, 1'b1);
    carry_in = 1'b0; #1; chk("R8 pass zero", carry_out, 1'b0);
  endtask

  task automatic t_arith();
    load_cfg(16'h9696, 5'b00100);
    for (int i = 0; i < 8; i++) begin
      logic a, b, c;
      a = i[0]; b = i[1]; c = i[2];
      din = {1'b0, ~c, b, a}; carry_in = c; #1;
      chk("R9 sum", le_out, a ^ b ^ c);
      chk("R9 carry", carry_out, (a & b) | (a & c) | (b & c));
    end
    carry_in = 1'b0;
  endtask

  task automatic t_cfg_ignore();
    load_cfg(16'hFFFF, 5'b00000);
    cfg_lut = 16'h0000; cfg_mode = 5'b00001; cfg_we = 1'b0;
    step(); step();
    din = 4'b0101; #1;
    chk("R10 table kept", le_out, 1'b1);
    carry_in = 1'b1; #1;
    chk("R10 mode kept", carry_out, 1'b1);
    carry_in = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    #2;
    step();
    t_reset();
    t_any_function();
    t_xnor();
    t_reg_path();
    t_ce_hold();
    t_feedback();
    t_chain();
    t_pack();
    t_carry();
    t_arith();
    t_cfg_ignore();
    finish_run();
  end

endmodule